// File: doc/BRIEF.md
# Two-Level Group and Channel Arbiter for DMA Service

This block decides which pending DMA channel is serviced next. Channels are organised into groups. A first arbitration stage picks one group among those with at least one requesting channel. A second stage then picks one channel inside that group. Each stage is set on its own to fixed priority or to round-robin. Fixed priority uses programmable priority values. Round-robin rotates through the candidates, starting just after the last one granted.

Only one channel is granted at a time. A grant, once issued, is held until the channel-done strobe arrives. A debug stall, when it is both enabled and asserted, prevents any new channel from starting. It does not disturb a channel that is already running, so that channel still completes normally. Descriptor fetch and data movement are handled elsewhere. This block only issues the grant valid flag and the granted channel number.

Top module: `dma_grp_arbiter`

## Requirements
- R1: While `rst_n` is low, and after reset with no requests, `grant_valid` is 0.
- R2: When no grant is active, the stall is not in force and any `req` bit is set, `grant_valid` is 1 after the next rising edge. `grant_ch` then names a channel whose `req` bit was set. Channel c belongs to group c/4 with local index c%4.
- R3: An active grant keeps `grant_valid` at 1 and `grant_ch` unchanged until `done` is seen high at a rising edge. On that edge the grant clears. A new grant can be issued no earlier than the following edge. `done` has no effect while no grant is active.
- R4: With `grp_rr_en`=0, the requesting group with the larger priority value in `grp_pri` wins. The priority of group g is bit g. On a tie, the lower-numbered group wins.
- R5: With `ch_rr_en`=0, the requesting channel of the winning group with the larger 2-bit priority value wins. The priority of channel c is `ch_pri[2c+1:2c]`. On a tie, the lower local index wins.
- R6: With `grp_rr_en`=1, the group search begins at the group just after the most recently granted group and wraps around. This pointer follows every grant in either mode. After reset it points so that group 0 is searched first.
- R7: With `ch_rr_en`=1, each group keeps the local index of its most recently granted channel. The search within the winning group begins just after that index and wraps around. After reset, local index 0 is searched first.
- R8: While `dbg_en` and `dbg_in` are both 1, no new grant is issued. A grant already active stays valid and still ends on `done`.
- R9: Grants resume once `dbg_in` falls or `dbg_en` is cleared. While `dbg_en` is 0, `dbg_in` has no effect.
- R10: Changes on `req` while a grant is active do not alter `grant_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 8 | Per-channel service request |
| ch_pri | input | 16 | Channel priority values, 2 bits per channel |
| grp_pri | input | 2 | Group priority values, 1 bit per group |
| grp_rr_en | input | 1 | 1 selects round-robin between groups |
| ch_rr_en | input | 1 | 1 selects round-robin within a group |
| dbg_en | input | 1 | Enables the debug stall |
| dbg_in | input | 1 | System debug request |
| done | input | 1 | Granted channel has finished |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 3 | Number of the granted channel |

## Verification
The bench applies every nonzero 8-bit request pattern in each of the four combinations of the two mode bits. It repeats this for three priority settings: ascending, mixed, and all tied. This separates a wrong comparison direction, a wrong tie rule, and a round-robin pointer that starts at the wrong place or is not kept per group. A run in which all eight channels request back to back shows the rotation order across both levels. Further sequences then exercise the stall:
- the stall held against a pending request;
- the stall lifted through each of its two inputs;
- the stall raised in the middle of an active grant;
- `dbg_in` toggled while `dbg_en` is 0.

Requests are changed while a grant is held, which shows that the held channel number never moves.

// File: rtl/arb2_pkg.sv
// Package: shared helpers for the two-level arbiter.
// Assumes: counts passed to idx_w are at least 1.
package arb2_pkg;

    // Width of an index able to name n items (never below 1 bit).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb2_pick.sv
// Module: arb2_pick
// One-of-N picker used at both arbitration levels. In fixed mode the
// requester with the largest priority wins (lowest index on a tie); in
// round-robin mode the search starts one past 'last' and wraps.
// Assumes: 'last' is below N. Purely combinational.
module arb2_pick #(
    parameter int N  = 4,
    parameter int PW = 2,
    localparam int IW = arb2_pkg::idx_w(N)
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] pri,
    input  logic            rr_en,
    input  logic [IW-1:0]   last,
    output logic            any,
    output logic [IW-1:0]   win
);

    logic          fx_hit;
    logic [IW-1:0] fx_idx;
    logic [PW-1:0] fx_pri;
    logic          rr_hit;
    logic [IW-1:0] rr_idx;

    // Fixed priority: scan upward, replace only on a strictly larger value.
    always_comb begin
        fx_hit = 1'b0;
        fx_idx = '0;
        fx_pri = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!fx_hit || pri[i*PW +: PW] > fx_pri)) begin
                fx_hit = 1'b1;
                fx_idx = IW'(i);
                fx_pri = pri[i*PW +: PW];
            end
        end
    end

    // Round-robin: first requester found walking forward from last+1.
    always_comb begin
        int j;
        rr_hit = 1'b0;
        rr_idx = '0;
        for (int k = 1; k <= N; k++) begin
            j = int'(last) + k;
            if (j >= N) j = j - N;
            if (!rr_hit && req[IW'(j)]) begin
                rr_hit = 1'b1;
                rr_idx = IW'(j);
            end
        end
    end

    // Output select between the two policies.
    always_comb begin
        any = |req;
        win = rr_en ? rr_idx : fx_idx;
    end

endmodule

// File: rtl/arb2_ctrl.sv
// Module: arb2_ctrl
// Grant register and round-robin history. Starts a grant when idle,
// requested and not stalled; holds it until 'done'; records the last
// granted group and, per group, the last granted local index.
// Assumes: g_win/l_win are valid whenever any_req is high.
module arb2_ctrl #(
    parameter int CPG = 4,
    parameter int NG  = 2,
    localparam int LIW = arb2_pkg::idx_w(CPG),
    localparam int GIW = arb2_pkg::idx_w(NG),
    localparam int CHW = arb2_pkg::idx_w(CPG * NG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_req,
    input  logic              stall,
    input  logic              done,
    input  logic [GIW-1:0]    g_win,
    input  logic [LIW-1:0]    l_win,
    output logic              grant_valid,
    output logic [CHW-1:0]    grant_ch,
    output logic [GIW-1:0]    grp_last,
    output logic [NG*LIW-1:0] ch_last
);

    logic start;

    // A new channel may start only from idle, with a request, unstalled.
    always_comb start = !grant_valid && any_req && !stall;

    // Grant state: set on start, cleared by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_ch    <= '0;
        end else if (grant_valid) begin
            if (done) grant_valid <= 1'b0;
        end else if (start) begin
            grant_valid <= 1'b1;
            grant_ch    <= CHW'(int'(g_win) * CPG + int'(l_win));
        end
    end

    // Round-robin history: follows every grant regardless of mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_last <= GIW'(NG - 1);
            for (int g = 0; g < NG; g++) ch_last[g*LIW +: LIW] <= LIW'(CPG - 1);
        end else if (start) begin
            grp_last <= g_win;
            ch_last[int'(g_win)*LIW +: LIW] <= l_win;
        end
    end

endmodule

// File: rtl/dma_grp_arbiter.sv
// Module: dma_grp_arbiter (top)
// Two-level arbiter: one picker per group chooses a channel, a group
// picker chooses among groups, and the controller issues and holds the
// grant. Debug stall (dbg_en & dbg_in) blocks new starts only.
// Assumes: channel c sits in group c / CPG at local index c % CPG.
module dma_grp_arbiter #(
    parameter int CPG       = 4,
    parameter int NG        = 2,
    parameter int CH_PRI_W  = 2,
    parameter int GRP_PRI_W = 1,
    localparam int NCH = CPG * NG,
    localparam int LIW = arb2_pkg::idx_w(CPG),
    localparam int GIW = arb2_pkg::idx_w(NG),
    localparam int CHW = arb2_pkg::idx_w(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          req,
    input  logic [NCH*CH_PRI_W-1:0] ch_pri,
    input  logic [NG*GRP_PRI_W-1:0] grp_pri,
    input  logic                    grp_rr_en,
    input  logic                    ch_rr_en,
    input  logic                    dbg_en,
    input  logic                    dbg_in,
    input  logic                    done,
    output logic                    grant_valid,
    output logic [CHW-1:0]          grant_ch
);

    logic [NG-1:0]     grp_req;
    logic [NG*LIW-1:0] ch_win;
    logic [NG*LIW-1:0] ch_last;
    logic [GIW-1:0]    grp_last;
    logic [GIW-1:0]    g_win;
    logic [LIW-1:0]    l_win;
    logic              any_req;
    logic              stall;

    // Second level: one channel picker per group.
    for (genvar g = 0; g < NG; g++) begin : g_chan
        arb2_pick #(.N(CPG), .PW(CH_PRI_W)) u_pick (
            .req   (req[g*CPG +: CPG]),
            .pri   (ch_pri[g*CPG*CH_PRI_W +: CPG*CH_PRI_W]),
            .rr_en (ch_rr_en),
            .last  (ch_last[g*LIW +: LIW]),
            .any   (grp_req[g]),
            .win   (ch_win[g*LIW +: LIW])
        );
    end

    // First level: picker over groups with a pending channel.
    arb2_pick #(.N(NG), .PW(GRP_PRI_W)) u_grp (
        .req   (grp_req),
        .pri   (grp_pri),
        .rr_en (grp_rr_en),
        .last  (grp_last),
        .any   (any_req),
        .win   (g_win)
    );

    // Route the winning group's channel choice and form the stall.
    always_comb begin
        l_win = ch_win[int'(g_win)*LIW +: LIW];
        stall = dbg_en && dbg_in;
    end

    arb2_ctrl #(.CPG(CPG), .NG(NG)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_req     (any_req),
        .stall       (stall),
        .done        (done),
        .g_win       (g_win),
        .l_win       (l_win),
        .grant_valid (grant_valid),
        .grant_ch    (grant_ch),
        .grp_last    (grp_last),
        .ch_last     (ch_last)
    );

endmodule

// File: rtl/dma_grp_arbiter_chk.sv
// Module: dma_grp_arbiter_chk
// Port-level properties of the arbiter, attached by bind.
// Assumes: synchronous active-low reset as in the top module.
module dma_grp_arbiter_chk #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req,
    input logic           dbg_en,
    input logic           dbg_in,
    input logic           done,
    input logic           grant_valid,
    input logic [CHW-1:0] grant_ch
);

    logic [NCH-1:0] req_q;

    // One-cycle copy of the requests, to see what a new grant was based on.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (|req) && !(dbg_en && dbg_in)) |=> grant_valid);

    assert_granted_was_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> req_q[grant_ch]);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !done) |=> (grant_valid && $stable(grant_ch)));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && done) |=> !grant_valid);

    assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && dbg_en && dbg_in) |=> !grant_valid);

    assert_idle_noreq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && req == '0) |=> !grant_valid);

endmodule

bind dma_grp_arbiter dma_grp_arbiter_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .dbg_en      (dbg_en),
    .dbg_in      (dbg_in),
    .done        (done),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch)
);

// File: tb/sim_dma_grp_arbiter.sv
// Bench: sweeps request patterns, modes and priority sets; keeps its own
// round-robin history and computes the expected winner from the rules.
module sim_dma_grp_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic [15:0] ch_pri = '0;
    logic [1:0] grp_pri = '0;
    logic       grp_rr_en = 1'b0;
    logic       ch_rr_en = 1'b0;
    logic       dbg_en = 1'b0;
    logic       dbg_in = 1'b0;
    logic       done = 1'b0;
    logic       grant_valid;
    logic [2:0] grant_ch;

    int n_chk = 0;
    int n_err = 0;
    int cp[8];
    int gp[2];
    int b_gl = 1;
    int b_cl[2] = '{3, 3};

    always #5 clk = ~clk;

    dma_grp_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .ch_pri(ch_pri), .grp_pri(grp_pri),
        .grp_rr_en(grp_rr_en), .ch_rr_en(ch_rr_en), .dbg_en(dbg_en), .dbg_in(dbg_in),
        .done(done), .grant_valid(grant_valid), .grant_ch(grant_ch)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner from the requirements and the bench's own history.
    function automatic int model(input logic [7:0] r);
        int gs = -1;
        int cs = -1;
        if (grp_rr_en) begin
            for (int k = 1; k <= 2; k++) begin
                int g = (b_gl + k) % 2;
                if (gs < 0 && (|r[g*4 +: 4])) gs = g;
            end
        end else begin
            for (int g = 0; g < 2; g++)
                if ((|r[g*4 +: 4]) && (gs < 0 || gp[g] > gp[gs])) gs = g;
        end
        if (ch_rr_en) begin
            for (int k = 1; k <= 4; k++) begin
                int c = (b_cl[gs] + k) % 4;
                if (cs < 0 && r[gs*4 + c]) cs = c;
            end
        end else begin
            for (int c = 0; c < 4; c++)
                if (r[gs*4 + c] && (cs < 0 || cp[gs*4 + c] > cp[gs*4 + cs])) cs = c;
        end
        return gs * 4 + cs;
    endfunction

    task automatic set_pri(input int sel);
        for (int c = 0; c < 8; c++) begin
            case (sel)
                0: cp[c] = c % 4;
                1: cp[c] = (c * 3 + 1) % 4;
                default: cp[c] = 1;
            endcase
            ch_pri[c*2 +: 2] = 2'(cp[c]);
        end
        gp[0] = (sel == 1) ? 1 : 0;
        gp[1] = (sel == 0) ? 1 : 0;
        grp_pri = {1'(gp[1]), 1'(gp[0])};
    endtask

    // Called at a negedge right after a grant edge: verify and track it.
    task automatic expect_grant(input logic [7:0] r, input string tag);
        int e = model(r);
        check(grant_valid === 1'b1, {tag, " grant_valid"}, int'(grant_valid), 1);
        check(int'(grant_ch) == e, tag, int'(grant_ch), e);
        b_gl = e / 4;
        b_cl[e / 4] = e % 4;
    endtask

    task automatic finish_grant(input string tag);
        done = 1'b1;
        @(negedge clk);
        check(grant_valid === 1'b0, {tag, " release"}, int'(grant_valid), 0);
        done = 1'b0;
        req = '0;
    endtask

    // One full grant cycle with a request pattern; optionally disturb req.
    task automatic one_trial(input logic [7:0] r, input string tag, input bit disturb);
        logic [2:0] held;
        req = r;
        @(negedge clk);
        expect_grant(r, tag);
        held = grant_ch;
        if (disturb) begin
            req = ~r;
            @(negedge clk);
            check(grant_valid === 1'b1 && grant_ch == held, "R10 held under req change",
                  int'(grant_ch), int'(held));
        end
        finish_grant("R3");
    endtask

    initial begin
        #1_000_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        set_pri(0);
        req = 8'hFF;
        repeat (3) @(negedge clk);
        check(grant_valid === 1'b0, "R1 in reset", int'(grant_valid), 0);
        req = '0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(grant_valid === 1'b0, "R1 idle no req", int'(grant_valid), 0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(grant_valid === 1'b0, "R3 done while idle", int'(grant_valid), 0);

        // Sweep: three priority sets, four mode pairs, all patterns.
        for (int ps = 0; ps < 3; ps++) begin
            set_pri(ps);
            for (int m = 0; m < 4; m++) begin
                string tag;
                grp_rr_en = m[1];
                ch_rr_en = m[0];
                tag = {grp_rr_en ? "R6" : "R4", "+", ch_rr_en ? "R7" : "R5",
                       (ps == 2) ? " ties" : ""};
                for (int p = 1; p < 256; p++) one_trial(8'(p), tag, (p % 17) == 0);
            end
        end

        // Rotation with all requesting in round-robin at both levels.
        grp_rr_en = 1'b1;
        ch_rr_en = 1'b1;
        for (int i = 0; i < 16; i++) one_trial(8'hFF, "R6+R7 rotation", 1'b0);

        // Stall holds off a pending request; release by dbg_in.
        grp_rr_en = 1'b0;
        ch_rr_en = 1'b0;
        set_pri(1);
        dbg_en = 1'b1;
        dbg_in = 1'b1;
        req = 8'h24;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(grant_valid === 1'b0, "R8 stall blocks start", int'(grant_valid), 0);
        end
        dbg_in = 1'b0;
        @(negedge clk);
        expect_grant(8'h24, "R9 resume by dbg_in");
        finish_grant("R3");

        // Release by clearing dbg_en.
        dbg_in = 1'b1;
        req = 8'h81;
        repeat (2) @(negedge clk);
        check(grant_valid === 1'b0, "R8 stall again", int'(grant_valid), 0);
        dbg_en = 1'b0;
        @(negedge clk);
        expect_grant(8'h81, "R9 resume by dbg_en");

        // Stall raised during an active grant: grant persists, ends on done.
        dbg_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(grant_valid === 1'b1, "R8 active grant kept", int'(grant_valid), 1);
        end
        finish_grant("R8 done under stall");
        req = 8'h10;
        repeat (3) @(negedge clk);
        check(grant_valid === 1'b0, "R8 no restart under stall", int'(grant_valid), 0);
        dbg_in = 1'b0;
        @(negedge clk);
        expect_grant(8'h10, "R9 resume after stall");
        finish_grant("R3");

        // dbg_in alone has no effect.
        dbg_en = 1'b0;
        dbg_in = 1'b1;
        one_trial(8'h42, "R9 dbg_in ignored", 1'b0);
        dbg_in = 1'b0;

        // Back-to-back: new grant one edge after release with req held.
        req = 8'h08;
        @(negedge clk);
        expect_grant(8'h08, "R2 first");
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        check(grant_valid === 1'b0, "R3 gap after done", int'(grant_valid), 0);
        @(negedge clk);
        expect_grant(8'h08, "R2 regrant");
        finish_grant("R3");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule